// File: doc/BRIEF.md
# UART Register Front-End with Event Controller

This block is the bus-facing side of a UART. A simple 32-bit register bus (byte offset, write strobe, read strobe, write data, read data) reaches two 16-entry byte FIFOs and a small event controller. A write to the data word queues a byte for the serial transmitter. A read of the data word takes the oldest received byte. Four single-bit flag words report whether each FIFO is full or empty.

The serial transmitter and receiver are outside the block. They connect through byte streams with valid/ready handshakes. The transmitter drains the TX FIFO, and the receiver fills the RX FIFO.

The event controller watches two sources: "TX FIFO has room" and "RX FIFO holds data". For each source it keeps a raw level, a sticky pending bit that software clears by writing 1, and an enable mask. One registered interrupt output combines them.

Top module: `uart_regfront`

## Requirements
- R1: Byte offsets are decoded as follows: data 0x00, TX-full 0x04, RX-empty 0x08, event level 0x0C, event pending 0x10, event enable 0x14, TX-empty 0x18, RX-full 0x1C. In the three event words, bit 0 is the TX source and bit 1 is the RX source.
- R2: A bus write to 0x00 pushes bits [7:0] into the TX FIFO, and the write is dropped when that FIFO is full. Bytes leave on the transmit stream in the order they were written.
- R3: A bus read of 0x00 returns the RX FIFO head in bits [7:0] and pops it. When the RX FIFO is empty, the read returns 0 and nothing is popped. For every read, the data is valid on the cycle after the read strobe.
- R4: Each FIFO holds 16 bytes. The flag words at 0x04, 0x08, 0x18 and 0x1C return their flag in bit 0 and zero in the other bits.
- R5: Reading 0x0C gives the current source levels: bit 0 is TX FIFO not full, and bit 1 is RX FIFO not empty. Writes to 0x0C change nothing.
- R6: A pending bit (0x10) is set on the clock after its source is high. Writing 1 to that bit clears it. While the source stays high, the bit is set again immediately, even right after a clear.
- R7: Writing 0x14 loads the enable mask: 1 enables a source and 0 disables it. The mask is 0 after reset.
- R8: The interrupt output is a register that, one clock later, follows the OR over sources of (pending AND enable).
- R9: Offsets without a mapping read as 0, and writes to them change no state.
- R10: The receive stream is accepted only when the RX FIFO is not full. The ready output shows this, and a byte offered while the FIFO is full is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 6 | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_re |
| tx_byte | output | 8 | Head of the TX FIFO toward the serial transmitter |
| tx_valid | output | 1 | TX FIFO not empty |
| tx_ready | input | 1 | Transmitter takes tx_byte this cycle |
| rx_byte | input | 8 | Byte from the serial receiver |
| rx_valid | input | 1 | rx_byte is offered |
| rx_ready | output | 1 | RX FIFO has room |
| irq | output | 1 | Registered interrupt |

## Verification
The assertions check on every cycle that:
- FIFO occupancy stays within its depth, and full or empty hold when no opposite operation occurs.
- A high source level forces its pending bit on the following clock.
- The interrupt tracks pending AND enable with one cycle of delay.
- Empty data reads and unmapped reads return zero.
- The level word matches the FIFO flags.

Only the bench scenarios can show the rest:
- Bytes come out in order.
- The seventeenth write and an offer into a full RX FIFO are really lost.
- A clear takes effect when the source is low.
- Writes to the level word and to unmapped offsets leave the registers unchanged.

// File: rtl/uart_regfront_pkg.sv
package uart_regfront_pkg;

  localparam int NUM_EVT = 2;
  localparam int EVT_TX  = 0;
  localparam int EVT_RX  = 1;

  localparam logic [7:0] OFF_DATA    = 8'h00;
  localparam logic [7:0] OFF_TXFULL  = 8'h04;
  localparam logic [7:0] OFF_RXEMPTY = 8'h08;
  localparam logic [7:0] OFF_LEVEL   = 8'h0C;
  localparam logic [7:0] OFF_PEND    = 8'h10;
  localparam logic [7:0] OFF_ENABLE  = 8'h14;
  localparam logic [7:0] OFF_TXEMPTY = 8'h18;
  localparam logic [7:0] OFF_RXFULL  = 8'h1C;

  typedef enum logic [3:0] {
    SEL_DATA, SEL_TXFULL, SEL_RXEMPTY, SEL_LEVEL, SEL_PEND,
    SEL_ENABLE, SEL_TXEMPTY, SEL_RXFULL, SEL_NONE
  } reg_sel_e;

  // Next state of one sticky, level-triggered pending bit.
  function automatic logic pend_next(input logic cur, input logic clr, input logic src);
    return (cur & ~clr) | src;
  endfunction

  function automatic reg_sel_e decode(input logic [7:0] off);
    case (off)
      OFF_DATA:    return SEL_DATA;
      OFF_TXFULL:  return SEL_TXFULL;
      OFF_RXEMPTY: return SEL_RXEMPTY;
      OFF_LEVEL:   return SEL_LEVEL;
      OFF_PEND:    return SEL_PEND;
      OFF_ENABLE:  return SEL_ENABLE;
      OFF_TXEMPTY: return SEL_TXEMPTY;
      OFF_RXFULL:  return SEL_RXFULL;
      default:     return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/urf_fifo.sv
module urf_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          full,
  output logic          empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  function automatic logic [AW-1:0] ptr_step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] count_q;
  logic          push_ok, pop_ok;

  assign full    = (count_q == CW'(DEPTH));
  assign empty   = (count_q == '0);
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;
  assign dout    = mem_q[rptr_q];

  always_ff @(posedge clk) begin
    if (push_ok) mem_q[wptr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else begin
      if (push_ok) wptr_q <= ptr_step(wptr_q);
      if (pop_ok)  rptr_q <= ptr_step(rptr_q);
      case ({push_ok, pop_ok})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(DEPTH));
  p_full_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full);
  p_empty_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !push) |=> empty);

endmodule

// File: rtl/urf_event_ctrl.sv
module urf_event_ctrl
  import uart_regfront_pkg::*;
#(
  parameter int NEV = NUM_EVT
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NEV-1:0] src,
  input  logic           clr_we,
  input  logic           en_we,
  input  logic [NEV-1:0] wbits,
  output logic [NEV-1:0] pending,
  output logic [NEV-1:0] enable,
  output logic           irq
);
  logic [NEV-1:0] pending_q, enable_q, clr_mask;
  logic           irq_q, irq_next;

  assign clr_mask = clr_we ? wbits : '0;
  assign irq_next = |(pending_q & enable_q);

  generate
    for (genvar i = 0; i < NEV; i++) begin : g_src
      always_ff @(posedge clk) begin
        if (!rst_n) pending_q[i] <= 1'b0;
        else        pending_q[i] <= pend_next(pending_q[i], clr_mask[i], src[i]);
      end
      p_level_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        src[i] |=> pending[i]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (en_we) enable_q <= wbits;
      irq_q <= irq_next;
    end
  end

  assign pending = pending_q;
  assign enable  = enable_q;
  assign irq     = irq_q;

  p_irq_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pending & enable)) |=> irq);
  p_irq_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(pending & enable)) |=> !irq);

endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
  import uart_regfront_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 32,
  parameter int BYTE_W     = 8,
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              tx_valid,
  input  logic              tx_ready,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_valid,
  output logic              rx_ready,
  output logic              irq
);
  reg_sel_e       sel;
  logic           tx_full, tx_empty, rx_full, rx_empty;
  logic           tx_push, rx_pop;
  logic [BYTE_W-1:0] rx_head;
  logic [NUM_EVT-1:0] evt_src, evt_pend, evt_en;
  logic [DATA_W-1:0]  rd_mux, rdata_q;

  assign sel = decode(8'(bus_addr));

  // Bus-side FIFO events, named for the checks below.
  assign tx_push = bus_we & (sel == SEL_DATA);
  assign rx_pop  = bus_re & (sel == SEL_DATA);

  urf_fifo #(.DW(BYTE_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push(tx_push), .din(bus_wdata[BYTE_W-1:0]),
    .pop(tx_ready), .dout(tx_byte),
    .full(tx_full), .empty(tx_empty)
  );

  urf_fifo #(.DW(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push(rx_valid), .din(rx_byte),
    .pop(rx_pop), .dout(rx_head),
    .full(rx_full), .empty(rx_empty)
  );

  assign tx_valid = ~tx_empty;
  assign rx_ready = ~rx_full;

  assign evt_src[EVT_TX] = ~tx_full;
  assign evt_src[EVT_RX] = ~rx_empty;

  urf_event_ctrl #(.NEV(NUM_EVT)) u_evt (
    .clk(clk), .rst_n(rst_n),
    .src(evt_src),
    .clr_we(bus_we & (sel == SEL_PEND)),
    .en_we(bus_we & (sel == SEL_ENABLE)),
    .wbits(bus_wdata[NUM_EVT-1:0]),
    .pending(evt_pend), .enable(evt_en), .irq(irq)
  );

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_DATA:    rd_mux = rx_empty ? '0 : DATA_W'(rx_head);
      SEL_TXFULL:  rd_mux = DATA_W'(tx_full);
      SEL_RXEMPTY: rd_mux = DATA_W'(rx_empty);
      SEL_LEVEL:   rd_mux = DATA_W'(evt_src);
      SEL_PEND:    rd_mux = DATA_W'(evt_pend);
      SEL_ENABLE:  rd_mux = DATA_W'(evt_en);
      SEL_TXEMPTY: rd_mux = DATA_W'(tx_empty);
      SEL_RXFULL:  rd_mux = DATA_W'(rx_full);
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_re) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;

  p_rd_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && rx_empty) |=> (bus_rdata == '0));
  p_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && sel == SEL_NONE) |=> (bus_rdata == '0));
  p_level_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && sel == SEL_LEVEL) |=>
      (bus_rdata[1:0] == {!$past(rx_empty), !$past(tx_full)}));
  p_rx_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |-> !rx_ready);

endmodule

// File: tb/uart_regfront_tb.sv
`timescale 1ns/1ps
module uart_regfront_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  bus_addr;
  logic        bus_we, bus_re;
  logic [31:0] bus_wdata, bus_rdata;
  logic [7:0]  tx_byte, rx_byte;
  logic        tx_valid, tx_ready, rx_valid, rx_ready, irq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  uart_regfront u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_ready(rx_ready), .irq(irq)
  );

  // Register reads expected right after reset (offset, value).
  localparam int NRST = 9;
  localparam logic [5:0]  T_ADDR [NRST] = '{6'h00, 6'h04, 6'h08, 6'h0C, 6'h10,
                                             6'h14, 6'h18, 6'h1C, 6'h20};
  localparam logic [31:0] T_EXP  [NRST] = '{32'h0, 32'h0, 32'h1, 32'h1, 32'h1,
                                             32'h0, 32'h1, 32'h0, 32'h0};

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_re = 1'b0; bus_wdata = '0;
    tx_ready = 1'b0; rx_byte = '0; rx_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R4 R9: reset-state register map walk
    for (int i = 0; i < NRST; i++) begin
      rd(T_ADDR[i], v);
      chk("R1", $sformatf("reset read off %h", T_ADDR[i]), v, T_EXP[i]);
    end
    chk("R8", "irq after reset", 32'(irq), 32'h0);

    // R5: a write to the level word is ignored
    wr(6'h0C, 32'h0);
    rd(6'h0C, v);
    chk("R5", "level after write", v, 32'h1);
    // R9: an unmapped write leaves the enable mask unchanged
    wr(6'h20, 32'h3);
    rd(6'h14, v);
    chk("R9", "enable after unmapped write", v, 32'h0);
    rd(6'h24, v);
    chk("R9", "unmapped read", v, 32'h0);

    // R7 R8: the enable mask gates the interrupt
    wr(6'h14, 32'h1);
    @(negedge clk);
    chk("R8", "irq with tx enabled", 32'(irq), 32'h1);
    rd(6'h14, v);
    chk("R7", "enable readback", v, 32'h1);
    wr(6'h14, 32'h0);
    @(negedge clk);
    chk("R8", "irq after disable", 32'(irq), 32'h0);

    // R6: a clear while the source is high is overridden at once
    wr(6'h10, 32'h1);
    rd(6'h10, v);
    chk("R6", "pending re-set while level high", v, 32'h1);

    // R2 R4: fill the TX FIFO with the transmitter stalled
    for (int i = 0; i < 16; i++) wr(6'h00, 32'hA0 + 32'(i));
    rd(6'h04, v); chk("R4", "tx full flag", v, 32'h1);
    rd(6'h18, v); chk("R4", "tx empty flag", v, 32'h0);
    rd(6'h0C, v); chk("R5", "level tx bit when full", v, 32'h0);
    wr(6'h00, 32'hEE);                     // dropped
    wr(6'h10, 32'h1);
    rd(6'h10, v); chk("R6", "pending cleared with level low", v, 32'h0);
    wr(6'h14, 32'h1);
    @(negedge clk);
    chk("R8", "irq stays low, pending clear", 32'(irq), 32'h0);

    // R2: drain and check order, no 17th byte
    tx_ready = 1'b1;
    for (int i = 0; i < 16; i++) begin
      chk("R2", "tx valid", 32'(tx_valid), 32'h1);
      chk("R2", $sformatf("tx byte %0d", i), 32'(tx_byte), 32'hA0 + 32'(i));
      @(negedge clk);
    end
    chk("R2", "tx empty after drain", 32'(tx_valid), 32'h0);
    tx_ready = 1'b0;
    @(negedge clk);
    chk("R8", "irq after tx room returns", 32'(irq), 32'h1);
    wr(6'h14, 32'h0);

    // R10 R4: fill RX, then offer one more
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      rx_byte = 8'h30 + 8'(i); rx_valid = 1'b1;
    end
    @(negedge clk);
    chk("R10", "rx_ready when full", 32'(rx_ready), 32'h0);
    rx_byte = 8'hEE;
    @(negedge clk);
    rx_valid = 1'b0;
    rd(6'h1C, v); chk("R4", "rx full flag", v, 32'h1);
    rd(6'h08, v); chk("R4", "rx empty flag", v, 32'h0);
    rd(6'h0C, v); chk("R5", "level with rx data", v, 32'h3);
    rd(6'h10, v); chk("R6", "pending rx bit", v, 32'h3);

    // R3: pop in order, then empty reads return 0
    for (int i = 0; i < 16; i++) begin
      rd(6'h00, v);
      chk("R3", $sformatf("rx byte %0d", i), v, 32'h30 + 32'(i));
    end
    rd(6'h00, v); chk("R3", "read when empty", v, 32'h0);
    rd(6'h08, v); chk("R3", "rx empty after drain", v, 32'h1);
    wr(6'h10, 32'h2);
    rd(6'h10, v); chk("R6", "rx pending cleared", v, 32'h1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule